// File: doc/BRIEF.md
# Two-Wire Bus Slave with Automatic Acknowledge

This block is the slave half of a two-wire (SMBus/I2C) serial port for a small controller. It oversamples the clock and data lines with the system clock. It detects START and STOP conditions and shifts in a 7-bit address followed by a direction bit. It then either receives bytes from the master or sends bytes to it. Both lines are open-drain: the block only ever pulls a line low, through its enable outputs.

Software sees a small register-style interface:
- an own address and a compare mask,
- a received-byte output and a transmit-byte write strobe,
- an interrupt flag that software clears with a strobe, and an acknowledge-request flag,
- a hardware-acknowledge enable and a slave inhibit.

With hardware acknowledge off, software decides each acknowledge at the moment it clears the interrupt. With hardware acknowledge on, the block acknowledges a matching address and every received byte by itself. In that case the interrupt arrives after the acknowledge bit. While the interrupt flag is set, the block holds the clock line low, so the master waits for software.

The software side uses single-cycle strobes, not a valid/ready stream. Back-pressure comes from the bus side: while an interrupt is pending, the block stretches the clock.

Top module: `smbus_hwack_slave`

## Requirements
- R1: A START seen while `cfg_inhibit` is 0 makes the block shift in the next 8 bits as an address byte, whichever direction bit it carries. A START seen while `cfg_inhibit` is 1 makes the block ignore the transfer: it gives no acknowledge and raises no interrupt.
- R2: With `cfg_hw_ack`=0, the falling SCL edge after the 8th address bit sets `irq` and `ack_req`, and `rd_data` then holds the address byte. SDA stays released until software decides. `sw_ack`, sampled with the `irq_clr` strobe, selects ACK (SDA held low during the 9th clock) or NACK.
- R3: With `cfg_hw_ack`=1, the address is acknowledged when ((byte[7:1] ^ `cfg_own_addr`) & `cfg_addr_mask`) == 0, where a mask bit of 1 means compare and byte[0] is the direction (1 = read). No interrupt comes before the acknowledge bit. On a match, `irq` is set at the falling edge that ends the 9th clock.
- R4: After an address is NACKed, either by software or by a hardware mismatch, the block raises no interrupt and never pulls SDA low until the next START.
- R5: In a master write with `cfg_hw_ack`=0, each data byte sets `irq` and `ack_req` before its acknowledge bit. Software's `sw_ack` then gives ACK or NACK on the 9th clock.
- R6: In a master write with `cfg_hw_ack`=1, each data byte is acknowledged automatically. `irq` is set after the acknowledge bit, with the byte on `rd_data`.
- R7: In a master read, the byte written through `wr_data` is sent most significant bit first. SDA is released for the 9th clock. The master's answer is shown on `master_ack` (1 = ACK, SDA low). `irq` is set only after that 9th clock, whatever the value of `cfg_hw_ack`.
- R8: A `wr_en` pulse while `irq` is pending after a master NACK sets `tx_err`. The next START clears `tx_err`.
- R9: If software clears the interrupt after a transmit interrupt without writing a byte first, the block becomes a receiver and releases SDA.
- R10: A STOP returns the block to idle with SDA released. Clock pulses that follow without a START get no response.
- R11: `scl_oe` holds SCL low while `irq` is set and releases it when software clears `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| cfg_own_addr | input | DATA_W-1 | Own 7-bit address |
| cfg_addr_mask | input | DATA_W-1 | Address compare mask, 1 = compare |
| cfg_hw_ack | input | 1 | Hardware acknowledge enable |
| cfg_inhibit | input | 1 | Ignore transfers that start while set |
| wr_data | input | DATA_W | Byte to transmit |
| wr_en | input | 1 | Write strobe for `wr_data` |
| rd_data | output | DATA_W | Last received byte (address or data) |
| irq_clr | input | 1 | Strobe that clears the interrupt |
| sw_ack | input | 1 | Acknowledge decision taken with `irq_clr` |
| irq | output | 1 | Interrupt flag |
| ack_req | output | 1 | Software acknowledge decision pending |
| master_ack | output | 1 | Master's answer to the last sent byte |
| tx_err | output | 1 | Byte written after a master NACK |

## Verification
Every reaction to a line edge passes through two synchronizer flops and one edge register. It then lands in the control register, so each flag and each SDA drive is settled three clock edges after the line moved. The bench holds every line level for eight cycles before it moves again, and it samples the flags at the end of that hold. Software strobes act on the next edge. The bench waits several cycles after each strobe before it looks at `sda_oe` or `scl_oe`. When it raises SCL, it waits until the line actually reads high, so stretched clocks are honoured.

// File: rtl/smbs_pkg.sv
package smbs_pkg;
  typedef enum logic [3:0] {
    S_IDLE,   // no transfer
    S_ADDR,   // shifting address byte
    S_AHOLD,  // address received, software decides
    S_AACK,   // address acknowledge bit on the bus
    S_RX,     // receiving data byte
    S_RHOLD,  // data received, software decides
    S_RACK,   // data acknowledge bit on the bus
    S_TX,     // sending data byte
    S_TACK,   // master's acknowledge bit
    S_POST,   // interrupt after an acknowledge cycle
    S_IGN     // ignored until next START
  } slv_state_t;
endpackage

// File: rtl/smbs_sync.sv
module smbs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_r, sda_r;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_r <= '1;
      sda_r <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_r <= {scl_r[STAGES-2:0], scl_i};
      sda_r <= {sda_r[STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s     = scl_r[STAGES-1];
  assign sda_s     = sda_r[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smbs_addr_match.sv
module smbs_addr_match #(
  parameter int AW = 7
) (
  input  logic [AW-1:0] addr_bits,
  input  logic [AW-1:0] own_addr,
  input  logic [AW-1:0] cmp_mask,
  output logic          hit
);
  assign hit = ((addr_bits ^ own_addr) & cmp_mask) == '0;
endmodule

// File: rtl/smbs_fsm.sv
module smbs_fsm
  import smbs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic          hw_ack,
  input  logic          inhibit,
  input  logic          addr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_en,
  input  logic          irq_clr,
  input  logic          sw_ack,
  output logic [DW-1:0] sh_byte,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          ack_req,
  output logic          master_ack,
  output logic          tx_err,
  output logic          sda_oe
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  slv_state_t    st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, rdat, txd;
  logic          tx_full, rw, irq_q, ackrq_q, mack_q, err_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      rdat    <= '0;
      txd     <= '0;
      tx_full <= 1'b0;
      rw      <= 1'b0;
      irq_q   <= 1'b0;
      ackrq_q <= 1'b0;
      mack_q  <= 1'b1;
      err_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      if (irq_clr && irq_q) begin
        irq_q   <= 1'b0;
        ackrq_q <= 1'b0;
      end
      if (wr_en) begin
        if (irq_q && st == S_POST && !mack_q) begin
          err_q <= 1'b1;
        end else begin
          txd     <= wr_data;
          tx_full <= 1'b1;
        end
      end
      if (start_det) begin
        sda_q  <= 1'b0;
        cnt    <= '0;
        err_q  <= 1'b0;
        mack_q <= 1'b1;
        st     <= inhibit ? S_IGN : S_ADDR;
      end else if (stop_det) begin
        sda_q <= 1'b0;
        st    <= S_IDLE;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              rdat <= sh;
              cnt  <= '0;
              if (st == S_ADDR) rw <= sh[0];
              if (!hw_ack) begin
                irq_q   <= 1'b1;
                ackrq_q <= 1'b1;
                st      <= (st == S_ADDR) ? S_AHOLD : S_RHOLD;
              end else if (st == S_RX || addr_hit) begin
                sda_q <= 1'b1;
                st    <= (st == S_ADDR) ? S_AACK : S_RACK;
              end else begin
                st <= S_IGN;
              end
            end
          end
          S_AHOLD, S_RHOLD: begin
            if (irq_clr && irq_q) begin
              if (sw_ack) begin
                sda_q <= 1'b1;
                st    <= (st == S_AHOLD) ? S_AACK : S_RACK;
              end else begin
                st <= (st == S_AHOLD) ? S_IGN : S_RACK;
              end
            end
          end
          S_AACK, S_RACK: begin
            if (scl_fall) begin
              sda_q <= 1'b0;
              cnt   <= '0;
              if (hw_ack) begin
                irq_q <= 1'b1;
                st    <= S_POST;
              end else if (st == S_AACK && rw && tx_full) begin
                sh      <= txd;
                sda_q   <= ~txd[DW-1];
                tx_full <= 1'b0;
                st      <= S_TX;
              end else begin
                st <= S_RX;
              end
            end
          end
          S_POST: begin
            if (irq_clr && irq_q) begin
              cnt <= '0;
              if (rw && tx_full) begin
                sh      <= txd;
                sda_q   <= ~txd[DW-1];
                tx_full <= 1'b0;
                st      <= S_TX;
              end else begin
                sda_q <= 1'b0;
                st    <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_q <= 1'b0;
                st    <= S_TACK;
              end else begin
                sh    <= {sh[DW-2:0], 1'b0};
                sda_q <= ~sh[DW-2];
              end
            end
          end
          S_TACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              irq_q <= 1'b1;
              cnt   <= '0;
              st    <= S_POST;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sh_byte    = sh;
  assign rd_data    = rdat;
  assign irq        = irq_q;
  assign ack_req    = ackrq_q;
  assign master_ack = mack_q;
  assign tx_err     = err_q;
  assign sda_oe     = sda_q;

  assert_ackreq_with_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> irq);
  assert_start_takes_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !inhibit) |=> (st == S_ADDR));
  assert_ignored_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN && !start_det) |=> (!$rose(irq) && !sda_oe));
  assert_err_needs_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_err) |-> !master_ack);
  assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (!sda_oe && st == S_IDLE));
  assert_release_for_mack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TACK) |-> !sda_oe);
endmodule

// File: rtl/smbus_hwack_slave.sv
module smbus_hwack_slave #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [DATA_W-2:0] cfg_own_addr,
  input  logic [DATA_W-2:0] cfg_addr_mask,
  input  logic              cfg_hw_ack,
  input  logic              cfg_inhibit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              irq_clr,
  input  logic              sw_ack,
  output logic              irq,
  output logic              ack_req,
  output logic              master_ack,
  output logic              tx_err
);
  localparam int AW = DATA_W - 1;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det, addr_hit;
  logic [DATA_W-1:0] sh_byte;

  smbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbs_addr_match #(.AW(AW)) u_match (
    .addr_bits(sh_byte[DATA_W-1:1]), .own_addr(cfg_own_addr),
    .cmp_mask(cfg_addr_mask), .hit(addr_hit)
  );

  smbs_fsm #(.DW(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .hw_ack(cfg_hw_ack), .inhibit(cfg_inhibit), .addr_hit(addr_hit),
    .wr_data(wr_data), .wr_en(wr_en), .irq_clr(irq_clr), .sw_ack(sw_ack),
    .sh_byte(sh_byte), .rd_data(rd_data), .irq(irq), .ack_req(ack_req),
    .master_ack(master_ack), .tx_err(tx_err), .sda_oe(sda_oe)
  );

  // Stretch the clock while software owes a response (R11)
  assign scl_oe = irq;
endmodule

// File: tb/sim_smbus_hwack_slave.sv
module sim_smbus_hwack_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] own = 7'h52, msk = 7'h7F;
  logic hwm = 1'b1, inh = 1'b0, wen = 1'b0, clr = 1'b0, swa = 1'b0;
  logic [7:0] wd = 8'h00;
  wire scl_oe, sda_oe, irq, ack_req, master_ack, tx_err;
  wire [7:0] rd_data;
  wire scl_l = scl_m & ~scl_oe;
  wire sda_l = sda_m & ~sda_oe;

  smbus_hwack_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_l), .sda_i(sda_l),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_own_addr(own), .cfg_addr_mask(msk),
    .cfg_hw_ack(hwm), .cfg_inhibit(inh), .wr_data(wd), .wr_en(wen),
    .rd_data(rd_data), .irq_clr(clr), .sw_ack(swa), .irq(irq),
    .ack_req(ack_req), .master_ack(master_ack), .tx_err(tx_err)
  );

  int checks = 0, errors = 0;

  // {byte, own, mask, hw_ack, sw_ack, expect_ack}
  localparam logic [24:0] VEC [7] = '{
    {8'hA4, 7'h52, 7'h7F, 1'b1, 1'b0, 1'b1},
    {8'hA6, 7'h52, 7'h7F, 1'b1, 1'b0, 1'b0},
    {8'hA6, 7'h52, 7'h7E, 1'b1, 1'b0, 1'b1},
    {8'h14, 7'h4A, 7'h3F, 1'b1, 1'b0, 1'b1},
    {8'h14, 7'h4A, 7'h7F, 1'b1, 1'b0, 1'b0},
    {8'h55, 7'h00, 7'h00, 1'b0, 1'b1, 1'b1},
    {8'hA4, 7'h52, 7'h7F, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic hold;
    repeat (8) @(negedge clk);
  endtask

  task automatic scl_high;
    scl_m = 1'b1;
    hold();
    while (!scl_l) @(negedge clk);
    hold();
  endtask

  task automatic clk_bit(input logic b, output logic v);
    sda_m = b;
    hold();
    scl_high();
    v = sda_l;
    hold();
    scl_m = 1'b0;
    hold();
  endtask

  task automatic send_byte(input logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], v);
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, v);
      d[i] = v;
    end
  endtask

  task automatic do_start;
    sda_m = 1'b1;
    hold();
    scl_high();
    sda_m = 1'b0;
    hold();
    scl_m = 1'b0;
    hold();
  endtask

  task automatic do_stop;
    sda_m = 1'b0;
    hold();
    scl_high();
    sda_m = 1'b1;
    hold();
  endtask

  task automatic sw_clear(input logic a);
    @(negedge clk);
    clr = 1'b1;
    swa = a;
    @(negedge clk);
    clr = 1'b0;
    hold();
  endtask

  task automatic sw_write(input logic [7:0] d);
    @(negedge clk);
    wd = d;
    wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
    hold();
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] b, r;
    logic hv, sv, ev;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    hold();
    chk1("reset irq", irq, 1'b0);
    chk1("reset ack_req", ack_req, 1'b0);
    chk1("reset sda_oe", sda_oe, 1'b0);
    chk1("reset scl_oe R11", scl_oe, 1'b0);
    chk1("reset tx_err", tx_err, 1'b0);

    // Address table: R1 R2 R3
    for (int i = 0; i < 7; i++) begin
      {b, own, msk, hv, sv, ev} = VEC[i];
      hwm = hv;
      do_start();
      send_byte(b);
      if (hv) begin
        chk1("R3 no irq before address ack", irq, 1'b0);
      end else begin
        chk1("R2 irq before address ack", irq, 1'b1);
        chk1("R2 ack_req set", ack_req, 1'b1);
        chk8("R2 rd_data address", rd_data, b);
        chk1("R2 SDA released while pending", sda_oe, 1'b0);
        sw_clear(sv);
      end
      clk_bit(1'b1, a);
      chk1(hv ? "R3 address ack by mask" : "R2 address ack by software", ~a, ev);
      if (hv && ev) begin
        chk1("R3 irq after address ack", irq, 1'b1);
        sw_clear(1'b1);
      end
      do_stop();
    end

    // R5: master write, software acknowledge
    hwm = 1'b0; own = 7'h52; msk = 7'h7F;
    do_start();
    send_byte(8'hA4);
    sw_clear(1'b1);
    clk_bit(1'b1, a);
    send_byte(8'h3C);
    chk1("R5 irq before data ack", irq, 1'b1);
    chk1("R5 ack_req for data", ack_req, 1'b1);
    chk8("R5 rd_data", rd_data, 8'h3C);
    chk1("R11 SCL stretched", scl_oe, 1'b1);
    sw_clear(1'b1);
    chk1("R11 SCL released", scl_oe, 1'b0);
    clk_bit(1'b1, a);
    chk1("R5 software ACK on bus", a, 1'b0);
    chk1("R5 no irq after ack", irq, 1'b0);
    send_byte(8'h77);
    sw_clear(1'b0);
    clk_bit(1'b1, a);
    chk1("R5 software NACK on bus", a, 1'b1);
    do_stop();

    // R6: master write, hardware acknowledge
    hwm = 1'b1;
    do_start();
    send_byte(8'hA4);
    clk_bit(1'b1, a);
    sw_clear(1'b1);
    send_byte(8'hC3);
    chk1("R6 no irq before data ack", irq, 1'b0);
    clk_bit(1'b1, a);
    chk1("R6 automatic data ACK", a, 1'b0);
    chk1("R6 irq after data ack", irq, 1'b1);
    chk8("R6 rd_data", rd_data, 8'hC3);
    sw_clear(1'b1);
    do_stop();

    // R4: ignored until next START
    do_start();
    send_byte(8'hA6);
    clk_bit(1'b1, a);
    chk1("R4 mismatch NACK", a, 1'b1);
    send_byte(8'hFF);
    chk1("R4 no irq while ignored", irq, 1'b0);
    clk_bit(1'b1, a);
    chk1("R4 no ack while ignored", a, 1'b1);
    do_start();
    send_byte(8'hA4);
    clk_bit(1'b1, a);
    chk1("R4 rearmed by START", a, 1'b0);
    sw_clear(1'b1);
    do_stop();

    // R1: inhibit
    inh = 1'b1;
    do_start();
    send_byte(8'hA4);
    chk1("R1 inhibited no irq", irq, 1'b0);
    clk_bit(1'b1, a);
    chk1("R1 inhibited no ack", a, 1'b1);
    do_stop();
    inh = 1'b0;

    // R7 R8 R9: master read, hardware acknowledge
    do_start();
    send_byte(8'hA5);
    clk_bit(1'b1, a);
    chk1("R7 read address ACK", a, 1'b0);
    chk1("R7 irq after address ack", irq, 1'b1);
    sw_write(8'h96);
    sw_clear(1'b1);
    recv_byte(r);
    chk8("R7 first byte on bus", r, 8'h96);
    chk1("R7 no irq before master ack", irq, 1'b0);
    clk_bit(1'b0, a);
    chk1("R7 irq after master ack", irq, 1'b1);
    chk1("R7 master_ack ACK", master_ack, 1'b1);
    sw_write(8'h5A);
    chk1("R8 no error after ACK", tx_err, 1'b0);
    sw_clear(1'b1);
    recv_byte(r);
    chk8("R7 second byte on bus", r, 8'h5A);
    clk_bit(1'b1, a);
    chk1("R7 master_ack NACK", master_ack, 1'b0);
    sw_write(8'h11);
    chk1("R8 write after NACK", tx_err, 1'b1);
    sw_clear(1'b1);
    chk1("R9 SDA released as receiver", sda_oe, 1'b0);
    do_stop();

    // R10: no START, no response
    scl_m = 1'b0;
    hold();
    send_byte(8'h00);
    clk_bit(1'b0, a);
    chk1("R10 idle no irq", irq, 1'b0);
    chk1("R10 idle SDA released", sda_oe, 1'b0);

    // R7 with software acknowledge, R8 clear, R9
    hwm = 1'b0;
    do_start();
    chk1("R8 START clears tx_err", tx_err, 1'b0);
    send_byte(8'hA5);
    chk1("R2 read address irq", irq, 1'b1);
    sw_write(8'h81);
    sw_clear(1'b1);
    clk_bit(1'b1, a);
    chk1("R2 read address ACK", a, 1'b0);
    recv_byte(r);
    chk8("R7 byte with software ack mode", r, 8'h81);
    chk1("R7 no early irq, software mode", irq, 1'b0);
    clk_bit(1'b0, a);
    chk1("R7 irq after ack, software mode", irq, 1'b1);
    sw_clear(1'b1);
    chk1("R9 no write becomes receiver", sda_oe, 1'b0);
    chk1("R9 irq cleared", irq, 1'b0);
    do_stop();

    finish_run();
  end
endmodule